// File: doc/BRIEF.md
# Host Bus Command Register Interface

This block is the slave side of a host bus for a voice control processor. The host reaches two registers. The command register takes 16-bit command words. The data register returns the words that a command has queued. Three commands are decoded. An interface configuration command sets the level of the wait output. A page command loads an 8-bit page number. A clock-status query queues two status words, one for each of two clocks. A read of the command register returns the stored page in its upper byte and the live interrupt line in bit 1.

The host bus can run 16 bits wide or 8 bits wide. A strap input chooses the width and is captured while reset is held. In 8-bit mode each 16-bit transfer takes two consecutive accesses to the same register, high byte first, and the block joins them into one word. The clock measurement itself is done outside the block. Each measured value arrives on an input port with a flag that says whether that clock is present, together with a frame-sync flag.

Top module: `hostcmd_if`

## Requirements
- R1: A completed command write whose upper byte is 0xFD sets `wait_out` to the inverse of bit 1 of its lower byte from the next cycle. So 0xFD04 drives it high and 0xFD06 drives it low.
- R2: After reset, `wait_out` is high. A command register read returns 0x0002 while `irq_n` is high.
- R3: Bit 1 of every command register read equals `irq_n` at the cycle the read is accepted. Bits 7:2 and bit 0 read as 0.
- R4: A completed command write 0xFEzz stores zz (0x00 to 0xFF) as the page. Later command register reads return zz in bits 15:8, so 0xFEAA followed by a read gives 0xAA02 while `irq_n` is high.
- R5: In 8-bit mode, two accesses to the same register make one 16-bit transfer. The first carries bits 15:8 and the second carries bits 7:0, both on bits 7:0 of the bus. Bits 15:8 of `bus_rdata` read as 0 in this mode.
- R6: The command word 0x8801 queues exactly two words for the data register (address 1). The first word read is the clock B status and the second is the clock A status.
- R7: A status word equals the measured value of its clock when that clock's presence flag and `fsync_ok` are both high. Otherwise it is 0x92FB.
- R8: A data register read with no word pending returns 0x0000 and leaves the pending count at zero.
- R9: Any command word other than 0xFDxx, 0xFExx and 0x8801 changes neither the page nor `wait_out`, and queues nothing.
- R10: The bus width is taken from `byte_mode_pin` (1 = 8-bit) during reset and stays fixed after reset is released, whatever the pin does afterwards.
- R11: The byte phase returns to the high-byte phase on reset and after each completed 16-bit transfer.
- R12: `bus_rdata` and `bus_rvalid` are registered. `bus_rvalid` is high in exactly the cycle after an accepted read access and low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_mode_pin | input | 1 | Bus width strap: 1 for 8-bit, 0 for 16-bit. Captured during reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = command register, 1 = data register |
| bus_wdata | input | 16 | Write data (bits 7:0 only in 8-bit mode) |
| bus_rdata | output | 16 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| irq_n | input | 1 | Interrupt line level, high while inactive |
| clkb_word | input | 16 | Measured value of clock B |
| clkb_ok | input | 1 | Clock B present |
| clka_word | input | 16 | Measured value of clock A |
| clka_ok | input | 1 | Clock A present |
| fsync_ok | input | 1 | Frame sync present |
| wait_out | output | 1 | Wait output, level set by the configuration command |

## Verification
The assertions assume that in 8-bit mode the host keeps both halves of a transfer on the same register and in the same direction. They also assume that the strap and the measured clock inputs hold steady around the accesses that use them. The stimulus always issues byte pairs as whole units, except for one deliberate lone high byte that is followed by a reset to test R11. It changes the clock inputs and the interrupt level only between accesses, and it flips the strap only after reset has been released.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;
  localparam int STATUS_WORDS = 2;

  localparam logic [HALF_W-1:0] OP_CONFIG   = 8'hFD;
  localparam logic [HALF_W-1:0] OP_PAGE     = 8'hFE;
  localparam logic [WORD_W-1:0] OP_CLKQUERY = 16'h8801;
  localparam logic [WORD_W-1:0] CLK_MISSING = 16'h92FB;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic              lo_rd;
    logic              data_sel;
    logic [WORD_W-1:0] word;
  } access_t;
endpackage

// File: rtl/hcmd_byte_merge.sv
module hcmd_byte_merge
  import hcmd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_mode,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output access_t       acc,
  output logic          phase_q
);
  localparam int H = W / 2;

  logic [H-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (byte_mode && bus_sel) begin
      phase_q <= !phase_q;
      if (!phase_q && bus_wr) hi_q <= bus_wdata[H-1:0];
    end
  end

  always_comb begin
    acc          = '0;
    acc.data_sel = bus_addr;
    if (!byte_mode) begin
      acc.wr   = bus_sel && bus_wr;
      acc.rd   = bus_sel && !bus_wr;
      acc.word = bus_wdata;
    end else begin
      acc.wr    = bus_sel && bus_wr && phase_q;
      acc.rd    = bus_sel && !bus_wr && !phase_q;
      acc.lo_rd = bus_sel && !bus_wr && phase_q;
      acc.word  = {hi_q, bus_wdata[H-1:0]};
    end
  end
endmodule

// File: rtl/hcmd_cmd_decode.sv
module hcmd_cmd_decode
  import hcmd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_stb,
  input  logic [W-1:0]   word,
  output logic [W/2-1:0] page_q,
  output logic           wait_q,
  output logic           clkq_stb
);
  localparam int H = W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      wait_q <= 1'b1;
    end else if (wr_stb) begin
      case (word[W-1:H])
        OP_CONFIG: wait_q <= !word[1];
        OP_PAGE:   page_q <= word[H-1:0];
        default:   ;
      endcase
    end
  end

  assign clkq_stb = wr_stb && (word == OP_CLKQUERY);
endmodule

// File: rtl/hcmd_status_queue.sv
module hcmd_status_queue #(
  parameter int DEPTH = 2,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [DEPTH-1:0][W-1:0]      load_words,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] slots;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots <= '0;
      count <= '0;
    end else if (load) begin
      slots <= load_words;
      count <= CW'(DEPTH);
    end else if (pop && count != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) slots[i] <= slots[i+1];
      slots[DEPTH-1] <= '0;
      count <= count - 1'b1;
    end
  end

  assign head = (count != '0) ? slots[0] : '0;
endmodule

// File: rtl/hostcmd_if.sv
module hostcmd_if
  import hcmd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         byte_mode_pin,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic         bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         bus_rvalid,
  input  logic         irq_n,
  input  logic [W-1:0] clkb_word,
  input  logic         clkb_ok,
  input  logic [W-1:0] clka_word,
  input  logic         clka_ok,
  input  logic         fsync_ok,
  output logic         wait_out
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(STATUS_WORDS + 1);

  logic          mode_q;
  access_t       acc;
  logic          phase_q;
  logic          acc_wr;
  logic [W-1:0]  acc_word;
  logic [H-1:0]  page_q;
  logic          clkq_stb;
  logic [W-1:0]  q_head;
  logic [CW-1:0] pend;
  logic [W-1:0]  src;
  logic [H-1:0]  lo_hold;
  logic [STATUS_WORDS-1:0][W-1:0] status_words;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= byte_mode_pin;
  end

  hcmd_byte_merge #(.W(W)) u_merge (
    .clk(clk), .rst(rst), .byte_mode(mode_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .acc(acc), .phase_q(phase_q)
  );

  assign acc_wr   = acc.wr && !acc.data_sel;
  assign acc_word = acc.word;

  hcmd_cmd_decode #(.W(W)) u_dec (
    .clk(clk), .rst(rst), .wr_stb(acc_wr), .word(acc_word),
    .page_q(page_q), .wait_q(wait_out), .clkq_stb(clkq_stb)
  );

  assign status_words[0] = (clkb_ok && fsync_ok) ? clkb_word : CLK_MISSING;
  assign status_words[1] = (clka_ok && fsync_ok) ? clka_word : CLK_MISSING;

  hcmd_status_queue #(.DEPTH(STATUS_WORDS), .W(W)) u_q (
    .clk(clk), .rst(rst), .load(clkq_stb), .load_words(status_words),
    .pop(acc.rd && acc.data_sel), .head(q_head), .count(pend)
  );

  assign src = acc.data_sel ? q_head : {page_q, {(H-2){1'b0}}, irq_n, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      lo_hold    <= '0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (acc.rd) begin
        bus_rdata <= mode_q ? {{H{1'b0}}, src[W-1:H]} : src;
        lo_hold   <= src[H-1:0];
      end else if (acc.lo_rd) begin
        bus_rdata <= {{H{1'b0}}, lo_hold};
      end
    end
  end
endmodule

// File: rtl/hcmd_if_chk.sv
module hcmd_if_chk #(
  parameter int W  = 16,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_addr,
  input logic          bus_rvalid,
  input logic [W-1:0]  bus_rdata,
  input logic          irq_n,
  input logic          wait_out,
  input logic          mode_q,
  input logic          phase_q,
  input logic          acc_wr,
  input logic [W-1:0]  acc_word,
  input logic [W/2-1:0] page_q,
  input logic [CW-1:0] pend
);
  p_cfg_wait_r1: assert property (@(posedge clk) disable iff (rst)
    acc_wr && acc_word[15:8] == 8'hFD |=> wait_out == !$past(acc_word[1]));

  p_irq_bit_r3: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && !bus_addr && !mode_q |=> bus_rdata[1] == $past(irq_n));

  p_page_load_r4: assert property (@(posedge clk) disable iff (rst)
    acc_wr && acc_word[15:8] == 8'hFE |=> page_q == $past(acc_word[7:0]));

  p_queue_fill_r6: assert property (@(posedge clk) disable iff (rst)
    acc_wr && acc_word == 16'h8801 |=> pend == 2);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    pend <= 2);

  p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    pend == 0 && !(acc_wr && acc_word == 16'h8801) |=> pend == 0);

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    acc_wr && acc_word[15:8] != 8'hFD && acc_word[15:8] != 8'hFE
    |=> $stable(page_q) && $stable(wait_out));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

  p_phase_clear_r11: assert property (@(posedge clk) disable iff (rst)
    phase_q && bus_sel |=> !phase_q);

  p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr |=> bus_rvalid);

  p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

bind hostcmd_if hcmd_if_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq_n(irq_n),
  .wait_out(wait_out), .mode_q(mode_q), .phase_q(phase_q), .acc_wr(acc_wr),
  .acc_word(acc_word), .page_q(page_q), .pend(pend)
);

// File: tb/tb_hostcmd_if.sv
module tb_hostcmd_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_mode_pin = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_n = 1'b1;
  logic [15:0] clkb_word = '0, clka_word = '0;
  logic        clkb_ok = 1'b0, clka_ok = 1'b0, fsync_ok = 1'b0;
  logic        wait_out;

  int checks = 0;
  int errors = 0;
  logic mode = 1'b0;

  always #10 clk = !clk;

  hostcmd_if dut (
    .clk(clk), .rst(rst), .byte_mode_pin(byte_mode_pin), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_n(irq_n),
    .clkb_word(clkb_word), .clkb_ok(clkb_ok), .clka_word(clka_word),
    .clka_ok(clka_ok), .fsync_ok(fsync_ok), .wait_out(wait_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; byte_mode_pin = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    byte_mode_pin = !m;
    mode = m;
  endtask

  task automatic access(input logic a, input logic w, input logic [15:0] d,
                        output logic [15:0] r, output logic v);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    r = bus_rdata; v = bus_rvalid;
  endtask

  task automatic wr16(input logic a, input logic [15:0] d);
    logic [15:0] r; logic v;
    if (mode) begin
      access(a, 1'b1, {8'h00, d[15:8]}, r, v);
      access(a, 1'b1, {8'h00, d[7:0]}, r, v);
    end else access(a, 1'b1, d, r, v);
  endtask

  task automatic rd16(input logic a, output logic [15:0] r);
    logic [15:0] r1, r2; logic v;
    if (mode) begin
      access(a, 1'b0, 16'h0, r1, v);
      access(a, 1'b0, 16'h0, r2, v);
      r = {r1[7:0], r2[7:0]};
      chk("R5 upper bus byte zero", {r1[15:8], r2[15:8]}, 16'h0);
    end else access(a, 1'b0, 16'h0, r, v);
  endtask

  task automatic run_suite();
    logic [15:0] r, ew0, ew1;
    logic v;
    logic [7:0] last_page;
    logic last_wait;
    irq_n = 1'b1;
    chk("R2 wait after reset", {15'h0, wait_out}, 16'h1);
    rd16(1'b0, r);
    chk("R2 cmd read after reset", r, 16'h0002);
    for (int p = 0; p < 256; p++) begin
      wr16(1'b0, {8'hFE, 8'(p)});
      irq_n = p[0];
      rd16(1'b0, r);
      chk("R4 R3 page readback", r, {8'(p), 6'b0, p[0], 1'b0});
    end
    irq_n = 1'b1;
    wr16(1'b0, 16'hFEAA);
    rd16(1'b0, r);
    chk("R4 0xFEAA gives 0xAA02", r, 16'hAA02);
    for (int c = 0; c < 256; c++) begin
      wr16(1'b0, {8'hFD, 8'(c)});
      chk("R1 wait level", {15'h0, wait_out}, {15'h0, !c[1]});
    end
    wr16(1'b0, 16'hFD04);
    chk("R1 0xFD04 high", {15'h0, wait_out}, 16'h1);
    wr16(1'b0, 16'hFD06);
    chk("R1 0xFD06 low", {15'h0, wait_out}, 16'h0);
    last_page = 8'hAA; last_wait = 1'b0;
    for (int h = 0; h < 256; h++) begin
      if (h == 8'hFD || h == 8'hFE) continue;
      wr16(1'b0, {8'(h), 8'h5A});
      chk("R9 wait unchanged", {15'h0, wait_out}, {15'h0, last_wait});
      rd16(1'b0, r);
      chk("R9 page unchanged", r, {last_page, 8'h02});
      rd16(1'b1, r);
      chk("R9 R8 nothing queued", r, 16'h0000);
    end
    for (int i = 0; i < 8; i++) begin
      clkb_word = 16'h1100 + 16'(i); clka_word = 16'h2200 + 16'(i);
      clkb_ok = i[0]; clka_ok = i[1]; fsync_ok = i[2];
      ew0 = (i[0] && i[2]) ? clkb_word : 16'h92FB;
      ew1 = (i[1] && i[2]) ? clka_word : 16'h92FB;
      wr16(1'b0, 16'h8801);
      rd16(1'b1, r);
      chk("R6 R7 word0 clock B", r, ew0);
      rd16(1'b1, r);
      chk("R6 R7 word1 clock A", r, ew1);
      rd16(1'b1, r);
      chk("R8 empty read zero", r, 16'h0000);
      rd16(1'b1, r);
      chk("R8 empty stays empty", r, 16'h0000);
    end
    access(1'b0, 1'b0, 16'h0, r, v);
    chk("R12 rvalid after read", {15'h0, v}, 16'h1);
    if (mode) access(1'b0, 1'b0, 16'h0, r, v);
    access(1'b0, 1'b1, 16'h00FE, r, v);
    chk("R12 rvalid low after write", {15'h0, v}, 16'h0);
    if (mode) access(1'b0, 1'b1, 16'h0000, r, v);
  endtask

  initial begin
    logic [15:0] r; logic v;
    do_reset(1'b0);
    run_suite();
    do_reset(1'b1);
    run_suite();
    // R5 high byte comes first
    wr16(1'b0, 16'hFE3C);
    access(1'b0, 1'b0, 16'h0, r, v);
    chk("R5 first byte is page", r, 16'h003C);
    access(1'b0, 1'b0, 16'h0, r, v);
    chk("R5 second byte is status", r, 16'h0002);
    // R10 strap held: pin is low now but byte pairs still merge
    chk("R10 pin flipped", {15'h0, byte_mode_pin}, 16'h0);
    wr16(1'b0, 16'hFE77);
    rd16(1'b0, r);
    chk("R10 byte mode held", r, 16'h7702);
    // R11 lone high byte then reset: phase restarts
    access(1'b0, 1'b1, 16'h00FE, r, v);
    do_reset(1'b1);
    access(1'b0, 1'b1, 16'h00FE, r, v);
    access(1'b0, 1'b1, 16'h0033, r, v);
    rd16(1'b0, r);
    chk("R11 phase cleared by reset", r, 16'h3302);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule